// File: doc/BRIEF.md
# Predicated vector branch-condition evaluator

This block decides whether one vectorised conditional branch is taken. A start strobe captures a vector of condition bits (one per condition field element), a predicate mask, the branch control options, an initial counter value and a vector length. The block then walks the elements one per clock in rising index order. For each element it tests the selected condition bit against the expected value and, if asked, decrements the counter and tests it for zero or non-zero. The results of all tested elements are combined into a single taken flag.

Predication decides what happens to an element whose mask bit is zero. With zeroing off, that element is skipped: it is not tested and does not decrement the counter. With zeroing on, the element is still processed, but its condition bit is replaced by a constant. The constant is zero normally and one when the substitute-one option is set. Software can therefore force the vector test to fail, or to pass, at a chosen position.

The block reports the final counter value and a one-cycle done pulse together with the taken flag. Target-address computation and register access belong to the surrounding pipeline.

Top module: `vbranch_eval`

## Requirements
- R1: After reset, done, taken and ctr_out are all 0.
- R2: A start seen in the idle state captures every input. Element k (k = 0, 1, ...) is processed k+1 clocks after the start edge. Done is high for exactly one cycle, beginning N+1 clock edges after the start edge, where N is the effective vector length. While idle, ctr_out does not change.
- R3: A start raised while an evaluation is in progress is ignored: the result and the timing of the running evaluation are unchanged.
- R4: With zeroing = 0, an element whose predicate bit is 0 is not tested and does not decrement the counter.
- R5: With zeroing = 1, an element whose predicate bit is 0 is tested using the substitute bit. The substitute is 0 when sub_one = 0 and 1 when sub_one = 1.
- R6: For each tested element with no_dec = 0, the counter is decremented by one modulo 2^CTR_W before the counter test. With no_dec = 1 the counter is not changed. ctr_out at done is the final counter value.
- R7: A tested element passes when both tests pass. The condition test passes when the bit equals expect_bit, or when ignore_cond = 1. The counter test passes when no_dec = 1, or when (counter == 0) equals ctr_zero_req, using the value after the decrement.
- R8: taken is the AND of the results of all tested elements, and is 0 when no element is tested.
- R9: A vector length of 0 gives done one clock after the start edge, with taken = 0 and ctr_out equal to ctr_in.
- R10: A vl_in above MAX_VL (default 64) is treated as MAX_VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an evaluation (accepted when idle) |
| vl_in | input | 7 | Vector length, clamped to MAX_VL |
| cond_in | input | 64 | Selected condition bit of each element, bit k for element k |
| pred_in | input | 64 | Predicate mask, bit k for element k |
| expect_bit | input | 1 | Expected condition bit value |
| ignore_cond | input | 1 | 1 = condition test always passes |
| no_dec | input | 1 | 1 = no counter decrement, counter test always passes |
| ctr_zero_req | input | 1 | 1 = counter test wants zero, 0 = wants non-zero |
| zeroing | input | 1 | 1 = masked-out elements use the substitute bit |
| sub_one | input | 1 | Substitute bit value for masked-out elements |
| ctr_in | input | 16 | Initial counter value |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch decision, valid at done |
| ctr_out | output | 16 | Counter value, final at done |

## Verification
The assertions assume that start is the only thing that begins an evaluation. They also assume that inputs other than start have meaning only on the edge where start is accepted. On that basis, the counter may step by at most one per element, and a zero-length start must produce done on the next edge. The stimulus drives inputs only at falling edges. Each start is a single-cycle strobe given from idle, except in the busy-start cases, where an extra strobe is deliberately placed mid-run with altered inputs. Random vector lengths include values above the maximum and zero, and counter seeds are kept small in many runs so that the zero test actually triggers.

// File: rtl/vbe_pkg.sv
package vbe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } vbe_state_e;

    typedef struct packed {
        logic expect_bit;
        logic ignore_cond;
        logic no_dec;
        logic ctr_zero_req;
        logic zeroing;
        logic sub_one;
    } vbe_ctrl_t;

endpackage

// File: rtl/vbe_elem_pick.sv
module vbe_elem_pick #(
    parameter int MAX_VL = 64,
    localparam int IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
    input  logic [MAX_VL-1:0] cond_vec,
    input  logic [MAX_VL-1:0] pred_vec,
    input  logic [IDX_W-1:0]  idx,
    input  logic              zeroing,
    input  logic              sub_one,
    output logic              tested,
    output logic              elem_bit
);

    logic cond_sel;
    logic pred_sel;

    always_comb begin
        cond_sel = cond_vec[idx];
        pred_sel = pred_vec[idx];
        tested   = pred_sel | zeroing;
        elem_bit = pred_sel ? cond_sel : sub_one;
    end

endmodule

// File: rtl/vbe_elem_judge.sv
module vbe_elem_judge
    import vbe_pkg::*;
#(
    parameter int CTR_W = 16
) (
    input  logic             tested,
    input  logic             elem_bit,
    input  vbe_ctrl_t        ctrl,
    input  logic [CTR_W-1:0] ctr_cur,
    output logic [CTR_W-1:0] ctr_nxt,
    output logic             pass
);

    logic cond_ok;
    logic ctr_ok;
    logic [CTR_W-1:0] ctr_dec;

    always_comb begin
        ctr_dec = ctr_cur - {{(CTR_W-1){1'b0}}, 1'b1};
        if (tested && !ctrl.no_dec) begin
            ctr_nxt = ctr_dec;
        end else begin
            ctr_nxt = ctr_cur;
        end
        cond_ok = ctrl.ignore_cond | (elem_bit == ctrl.expect_bit);
        ctr_ok  = ctrl.no_dec | ((ctr_dec == '0) == ctrl.ctr_zero_req);
        pass    = cond_ok & ctr_ok;
    end

endmodule

// File: rtl/vbranch_eval.sv
module vbranch_eval
    import vbe_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int CTR_W  = 16,
    localparam int IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1,
    localparam int VL_W  = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VL_W-1:0]   vl_in,
    input  logic [MAX_VL-1:0] cond_in,
    input  logic [MAX_VL-1:0] pred_in,
    input  logic              expect_bit,
    input  logic              ignore_cond,
    input  logic              no_dec,
    input  logic              ctr_zero_req,
    input  logic              zeroing,
    input  logic              sub_one,
    input  logic [CTR_W-1:0]  ctr_in,
    output logic              done,
    output logic              taken,
    output logic [CTR_W-1:0]  ctr_out
);

    typedef struct packed {
        vbe_state_e        state;
        logic [MAX_VL-1:0] cond;
        logic [MAX_VL-1:0] pred;
        vbe_ctrl_t         ctrl;
        logic [CTR_W-1:0]  ctr;
        logic [IDX_W-1:0]  last;
        logic [IDX_W-1:0]  idx;
        logic              any;
        logic              all;
        logic              taken;
    } vbe_regs_t;

    vbe_regs_t r_d;
    vbe_regs_t r_q;

    logic             e_tested;
    logic             e_bit;
    logic             e_pass;
    logic [CTR_W-1:0] e_ctr;
    logic [VL_W-1:0]  vl_eff;
    logic             any_n;
    logic             all_n;
    logic             run_w;
    logic             nodec_w;

    vbe_elem_pick #(.MAX_VL(MAX_VL)) u_pick (
        .cond_vec (r_q.cond),
        .pred_vec (r_q.pred),
        .idx      (r_q.idx),
        .zeroing  (r_q.ctrl.zeroing),
        .sub_one  (r_q.ctrl.sub_one),
        .tested   (e_tested),
        .elem_bit (e_bit)
    );

    vbe_elem_judge #(.CTR_W(CTR_W)) u_judge (
        .tested   (e_tested),
        .elem_bit (e_bit),
        .ctrl     (r_q.ctrl),
        .ctr_cur  (r_q.ctr),
        .ctr_nxt  (e_ctr),
        .pass     (e_pass)
    );

    always_comb begin
        r_d    = r_q;
        vl_eff = (vl_in > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vl_in;
        any_n  = r_q.any | e_tested;
        all_n  = r_q.all & (e_pass | ~e_tested);
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.cond              = cond_in;
                    r_d.pred              = pred_in;
                    r_d.ctrl.expect_bit   = expect_bit;
                    r_d.ctrl.ignore_cond  = ignore_cond;
                    r_d.ctrl.no_dec       = no_dec;
                    r_d.ctrl.ctr_zero_req = ctr_zero_req;
                    r_d.ctrl.zeroing      = zeroing;
                    r_d.ctrl.sub_one      = sub_one;
                    r_d.ctr               = ctr_in;
                    r_d.idx               = '0;
                    r_d.last              = IDX_W'(vl_eff - 1'b1);
                    r_d.any               = 1'b0;
                    r_d.all               = 1'b1;
                    r_d.taken             = 1'b0;
                    r_d.state             = (vl_eff == '0) ? ST_FIN : ST_RUN;
                end
            end
            ST_RUN: begin
                r_d.ctr = e_ctr;
                r_d.any = any_n;
                r_d.all = all_n;
                r_d.idx = r_q.idx + 1'b1;
                if (r_q.idx == r_q.last) begin
                    r_d.taken = any_n & all_n;
                    r_d.state = ST_FIN;
                end
            end
            ST_FIN: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done    = (r_q.state == ST_FIN);
    assign taken   = r_q.taken;
    assign ctr_out = r_q.ctr;
    assign run_w   = (r_q.state == ST_RUN);
    assign nodec_w = r_q.ctrl.no_dec;

endmodule

// File: rtl/vbe_checker.sv
module vbe_checker #(
    parameter int CTR_W = 16,
    parameter int VL_W  = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [VL_W-1:0]  vl_in,
    input logic             done,
    input logic [CTR_W-1:0] ctr_out,
    input logic             run_w,
    input logic             nodec_w
);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_w && !done && !start) |=> $stable(ctr_out));

    // R6
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_w |=> (ctr_out == $past(ctr_out)) ||
                  (ctr_out == CTR_W'($past(ctr_out) - 1'b1)));

    // R6
    nodec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && nodec_w) |=> $stable(ctr_out));

    // R9
    vl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_w && !done && start && vl_in == '0) |=> done);

endmodule

bind vbranch_eval vbe_checker #(.CTR_W(CTR_W), .VL_W(VL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .vl_in   (vl_in),
    .done    (done),
    .ctr_out (ctr_out),
    .run_w   (run_w),
    .nodec_w (nodec_w)
);

// File: tb/tb_vbranch_eval.sv
`timescale 1ns/1ps
module tb_vbranch_eval;

    localparam int MAX_VL = 64;
    localparam int CTR_W  = 16;
    localparam int VL_W   = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [VL_W-1:0]   vl_in = '0;
    logic [MAX_VL-1:0] cond_in = '0;
    logic [MAX_VL-1:0] pred_in = '0;
    logic              expect_bit = 1'b0;
    logic              ignore_cond = 1'b0;
    logic              no_dec = 1'b0;
    logic              ctr_zero_req = 1'b0;
    logic              zeroing = 1'b0;
    logic              sub_one = 1'b0;
    logic [CTR_W-1:0]  ctr_in = '0;
    logic              done;
    logic              taken;
    logic [CTR_W-1:0]  ctr_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    vbranch_eval #(.MAX_VL(MAX_VL), .CTR_W(CTR_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
        .cond_in(cond_in), .pred_in(pred_in), .expect_bit(expect_bit),
        .ignore_cond(ignore_cond), .no_dec(no_dec), .ctr_zero_req(ctr_zero_req),
        .zeroing(zeroing), .sub_one(sub_one), .ctr_in(ctr_in),
        .done(done), .taken(taken), .ctr_out(ctr_out)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference model built from R4-R8 and R10
    function automatic void model(input int vl, input logic [63:0] c, input logic [63:0] p,
                                  input logic eb, input logic ic, input logic nd,
                                  input logic zr, input logic zf, input logic so,
                                  input logic [CTR_W-1:0] c0,
                                  output logic tk, output logic [CTR_W-1:0] cf);
        logic any = 1'b0;
        logic all = 1'b1;
        logic [CTR_W-1:0] ct = c0;
        int n = (vl > MAX_VL) ? MAX_VL : vl;
        for (int k = 0; k < n; k++) begin
            logic b;
            logic ok;
            if (p[k] || zf) begin
                b = p[k] ? c[k] : so;
                if (!nd) ct = ct - 1'b1;
                ok = (ic || b == eb) && (nd || ((ct == 0) == zr));
                any = 1'b1;
                all = all & ok;
            end
        end
        tk = any & all;
        cf = ct;
    endfunction

    task automatic run_case(input string tag, input int vl, input logic [63:0] c,
                            input logic [63:0] p, input logic eb, input logic ic,
                            input logic nd, input logic zr, input logic zf,
                            input logic so, input logic [CTR_W-1:0] c0,
                            input bit busy_poke);
        logic tk_e;
        logic [CTR_W-1:0] cf_e;
        int n = 0;
        int n_exp;
        model(vl, c, p, eb, ic, nd, zr, zf, so, c0, tk_e, cf_e);
        n_exp = (vl > MAX_VL) ? MAX_VL : vl;
        @(negedge clk);
        vl_in = VL_W'(vl); cond_in = c; pred_in = p; expect_bit = eb;
        ignore_cond = ic; no_dec = nd; ctr_zero_req = zr; zeroing = zf;
        sub_one = so; ctr_in = c0; start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        forever begin
            @(negedge clk);
            start = 1'b0;
            if (done) break;
            n = n + 1;
            if (busy_poke && n == 1) begin
                // R3: altered inputs and a second strobe mid-run
                cond_in = ~c; pred_in = ~p; ctr_in = c0 + 16'd7;
                vl_in = 7'd1; start = 1'b1;
            end
            if (n > 200) break;
        end
        check({tag, " latency R2"}, n, n_exp);
        check({tag, " taken R8"}, taken, tk_e);
        check({tag, " ctr R6"}, ctr_out, cf_e);
    endtask

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("reset done R1", done, 0);
        check("reset taken R1", taken, 0);
        check("reset ctr R1", ctr_out, 0);
        rst_n = 1'b1;

        // R9: zero length
        run_case("vl0 R9", 0, '1, '1, 1, 0, 0, 0, 0, 0, 16'h1234, 0);
        // R4: all masked, zeroing off -> nothing tested, counter unchanged
        run_case("allmask R4", 8, '1, '0, 1, 0, 0, 0, 0, 0, 16'h0040, 0);
        // R4: masked element that would fail is skipped, no decrement
        run_case("skipfail R4", 4, 64'hB, 64'hB, 1, 0, 0, 0, 0, 0, 16'h0010, 0);
        // R5: masked element 3 replaced by 0 -> fails
        run_case("sub0 R5", 6, '1, 64'h37, 1, 0, 1, 0, 1, 0, 16'h0005, 0);
        // R5: replaced by 1 -> passes
        run_case("sub1 R5", 6, '1, 64'h37, 1, 0, 1, 0, 1, 1, 16'h0005, 0);
        // R7: ignore_cond makes mismatched bits pass
        run_case("ignore R7", 5, '0, '1, 1, 1, 1, 0, 0, 0, 16'h0003, 0);
        // R6/R7: wrap from zero, non-zero requested
        run_case("wrap R6", 1, '1, '1, 1, 0, 0, 0, 0, 0, 16'h0000, 0);
        // R7: counter reaches zero at last element with zero requested
        run_case("ctrzero R7", 3, '1, '1, 1, 0, 0, 1, 0, 0, 16'h0003, 0);
        // R10: over-long length clamps to 64
        run_case("clamp R10", 70, '1, '1, 1, 0, 0, 0, 0, 0, 16'h0100, 0);
        // R3: start while busy ignored
        run_case("busy R3", 12, 64'hFFF, 64'hF0F, 1, 0, 0, 0, 1, 1, 16'h0020, 1);

        for (int t = 0; t < 300; t++) begin
            logic [63:0] c;
            logic [63:0] p;
            int vl;
            logic [CTR_W-1:0] c0;
            c = {$urandom, $urandom};
            if ($urandom_range(0, 1) == 1) c = c | {$urandom, $urandom} | {$urandom, $urandom};
            p = {$urandom, $urandom};
            if ($urandom_range(0, 2) == 0) p = p | {$urandom, $urandom};
            vl = $urandom_range(0, 70);
            c0 = ($urandom_range(0, 1) == 1) ? CTR_W'($urandom_range(0, 12)) : CTR_W'($urandom);
            run_case("rand R7", vl, c, p, 1'($urandom), 1'($urandom), 1'($urandom),
                     1'($urandom), 1'($urandom), 1'($urandom), c0,
                     ($urandom_range(0, 7) == 0) && vl >= 3);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule